// File: doc/BRIEF.md
# Boot Chip-Select Controller

This block drives chip-select 0 of a local bus so that a boot ROM can be reached before software has set up the memory controller. After a hardware reset it is in boot mode. In that mode every access on the bus selects bank 0, whatever its address and whether it reads or writes. The port size of the bank comes from configuration pins that are sampled while reset is held.

Software programs two registers through a simple write interface. The base register holds the bank address, a valid bit and a write-protect bit. The option register holds the address mask. The first write to the option register ends boot mode. From the next cycle on, chip-select 0 decodes addresses against the base and mask like any other bank. Once boot mode has ended, only another hardware reset can bring it back.

Chip-select 0 is registered: an access strobe sampled on one clock edge produces the select on the output for the following cycle.

Top module: `bootcs_ctrl`

## Requirements
- R1: On every clock edge with `rst_n` low, the state is reset. After release, `boot_mode_o` is 1 and `cs0_o` is 0. `port_size_o` equals the value of `cfg_psize_i` on the last clock edge on which `rst_n` was low.
- R2: While `boot_mode_o` is 1, any access (`acc_valid_i` = 1) asserts `cs0_o` in the next cycle. This holds for every address, for reads and writes alike, and whatever the write-protect bit is set to.
- R3: `cs0_o` is registered. It is high for exactly the cycle after an edge that sampled `acc_valid_i` = 1 with a hit. It is low after any edge that sampled `acc_valid_i` = 0.
- R4: A write to the base register (`reg_wr_base_i`) does not end boot mode.
- R5: A write to the option register (`reg_wr_opt_i`) clears `boot_mode_o` from the next cycle. An access sampled on the same edge as that write is still decoded in boot mode.
- R6: In normal mode, an access asserts `cs0_o` only if two conditions hold. The base valid bit (`reg_wdata_i` bit ADDR_W+1 when the base register is written) must be 1. The address must also satisfy `((acc_addr_i ^ base) & mask) == 0`, where base comes from `reg_wdata_i[ADDR_W-1:0]` of a base write and mask from `reg_wdata_i[ADDR_W-1:0]` of an option write.
- R7: In normal mode, if the base write-protect bit (`reg_wdata_i` bit ADDR_W) is 1, write accesses (`acc_write_i` = 1) never assert `cs0_o`. Reads still decode per R6.
- R8: After boot mode has ended, no register write of any kind sets `boot_mode_o` again.
- R9: Outside reset, `port_size_o` holds its value whatever `cfg_psize_i` does.
- R10: A reset applied during normal operation restores boot mode and samples the port size again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| cfg_psize_i | input | PSIZE_W | Reset-time port size configuration pins |
| reg_wr_base_i | input | 1 | Write strobe for the base register |
| reg_wr_opt_i | input | 1 | Write strobe for the option register |
| reg_wdata_i | input | ADDR_W+2 | Register write data: {valid, write-protect, address} for base, low ADDR_W bits as mask for option |
| acc_valid_i | input | 1 | Bus access strobe |
| acc_write_i | input | 1 | Access direction, 1 = write |
| acc_addr_i | input | ADDR_W | Access address |
| cs0_o | output | 1 | Chip-select 0, active high, registered |
| port_size_o | output | PSIZE_W | Port size latched during reset |
| boot_mode_o | output | 1 | 1 while the boot decode is in force |

## Verification
The assertions check on every cycle that:
- boot mode can only be left, never re-entered outside reset;
- only an option write ends it;
- boot mode selects every access;
- idle cycles leave the select low;
- write protection blocks writes in normal mode;
- the latched port size never moves after release.

Only the bench's scenarios can show the rest:
- the address-match arithmetic over the whole address space;
- the effect of the valid bit;
- the ordering between an option write and an access on the same edge;
- the value the port size captures;
- the return of boot mode after a second reset.

// File: rtl/bootcs_pkg.sv
package bootcs_pkg;

    typedef enum logic {
        MODE_BOOT   = 1'b0,
        MODE_NORMAL = 1'b1
    } cs_mode_e;

    typedef struct packed {
        logic valid;
        logic wprot;
    } base_ctl_t;

endpackage

// File: rtl/bootcs_cfg_reg.sv
module bootcs_cfg_reg
    import bootcs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PSIZE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PSIZE_W-1:0] cfg_psize,
    input  logic               wr_base,
    input  logic               wr_opt,
    input  logic [ADDR_W+1:0]  wdata,
    output logic [ADDR_W-1:0]  base_addr,
    output base_ctl_t          base_ctl,
    output logic [ADDR_W-1:0]  opt_mask,
    output cs_mode_e           mode,
    output logic [PSIZE_W-1:0] psize
);

    localparam int WP_BIT = ADDR_W;
    localparam int VL_BIT = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        base_ctl_t          ctl;
        logic [ADDR_W-1:0]  mask;
        cs_mode_e           mode;
        logic [PSIZE_W-1:0] psize;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_base) begin
            st_d.base      = wdata[ADDR_W-1:0];
            st_d.ctl.wprot = wdata[WP_BIT];
            st_d.ctl.valid = wdata[VL_BIT];
        end
        if (wr_opt) begin
            st_d.mask = wdata[ADDR_W-1:0];
            st_d.mode = MODE_NORMAL;
        end
        if (!rst_n) begin
            st_d.base      = '0;
            st_d.ctl.wprot = 1'b0;
            st_d.ctl.valid = 1'b0;
            st_d.mask      = '0;
            st_d.mode      = MODE_BOOT;
            st_d.psize     = cfg_psize;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign base_addr = st_q.base;
    assign base_ctl  = st_q.ctl;
    assign opt_mask  = st_q.mask;
    assign mode      = st_q.mode;
    assign psize     = st_q.psize;

endmodule

// File: rtl/bootcs_match.sv
module bootcs_match
    import bootcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              boot,
    input  base_ctl_t         ctl,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = ~mask[i] | ~(addr[i] ^ base_addr[i]);
    end

    logic normal_hit;

    always_comb begin
        normal_hit = ctl.valid & &bit_ok & ~(write & ctl.wprot);
        hit        = boot | normal_hit;
    end

endmodule

// File: rtl/bootcs_ctrl.sv
module bootcs_ctrl
    import bootcs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PSIZE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PSIZE_W-1:0] cfg_psize_i,
    input  logic               reg_wr_base_i,
    input  logic               reg_wr_opt_i,
    input  logic [ADDR_W+1:0]  reg_wdata_i,
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    output logic               cs0_o,
    output logic [PSIZE_W-1:0] port_size_o,
    output logic               boot_mode_o
);

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] opt_mask;
    base_ctl_t         base_ctl;
    cs_mode_e          mode;
    logic              boot;
    logic              hit;

    bootcs_cfg_reg #(
        .ADDR_W (ADDR_W),
        .PSIZE_W(PSIZE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_psize(cfg_psize_i),
        .wr_base  (reg_wr_base_i),
        .wr_opt   (reg_wr_opt_i),
        .wdata    (reg_wdata_i),
        .base_addr(base_addr),
        .base_ctl (base_ctl),
        .opt_mask (opt_mask),
        .mode     (mode),
        .psize    (port_size_o)
    );

    assign boot = (mode == MODE_BOOT);

    bootcs_match #(
        .ADDR_W(ADDR_W)
    ) u_match (
        .boot     (boot),
        .ctl      (base_ctl),
        .base_addr(base_addr),
        .mask     (opt_mask),
        .addr     (acc_addr_i),
        .write    (acc_write_i),
        .hit      (hit)
    );

    typedef struct packed {
        logic cs;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.cs = rst_n & acc_valid_i & hit;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign cs0_o       = out_q.cs;
    assign boot_mode_o = boot;

endmodule

// File: rtl/bootcs_ctrl_chk.sv
module bootcs_ctrl_chk #(
    parameter int PSIZE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid_i,
    input logic               acc_write_i,
    input logic               reg_wr_opt_i,
    input logic               cs0_o,
    input logic               boot_mode_o,
    input logic [PSIZE_W-1:0] port_size_o,
    input logic               wprot
);

    a_r2_boot_selects_all: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode_o && acc_valid_i) |=> cs0_o);

    a_r3_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !cs0_o);

    a_r4_boot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode_o && !reg_wr_opt_i) |=> boot_mode_o);

    a_r5_opt_ends_boot: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_opt_i |=> !boot_mode_o);

    a_r7_wprot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_mode_o && acc_valid_i && acc_write_i && wprot) |=> !cs0_o);

    a_r8_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_mode_o |=> !boot_mode_o);

    a_r9_psize_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(port_size_o));

endmodule

bind bootcs_ctrl bootcs_ctrl_chk #(
    .PSIZE_W(PSIZE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .reg_wr_opt_i(reg_wr_opt_i),
    .cs0_o       (cs0_o),
    .boot_mode_o (boot_mode_o),
    .port_size_o (port_size_o),
    .wprot       (base_ctl.wprot)
);

// File: tb/tb_bootcs_ctrl.sv
`timescale 1ns/1ps
module tb_bootcs_ctrl;

    localparam int AW = 6;
    localparam int PW = 2;
    localparam int NADDR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [PW-1:0] cfg_psize;
    logic          wr_base, wr_opt;
    logic [AW+1:0] wdata;
    logic          acc_valid, acc_write;
    logic [AW-1:0] acc_addr;
    logic          cs0;
    logic [PW-1:0] psize;
    logic          boot;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bootcs_ctrl #(.ADDR_W(AW), .PSIZE_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_psize_i(cfg_psize),
        .reg_wr_base_i(wr_base), .reg_wr_opt_i(wr_opt), .reg_wdata_i(wdata),
        .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
        .cs0_o(cs0), .port_size_o(psize), .boot_mode_o(boot)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic w);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic reg_write(input logic is_opt, input logic [AW+1:0] d);
        @(negedge clk);
        wdata = d;
        if (is_opt) wr_opt = 1'b1; else wr_base = 1'b1;
        @(negedge clk);
        wr_opt = 1'b0; wr_base = 1'b0;
    endtask

    task automatic do_reset(input logic [PW-1:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_psize = ~cfg;
        repeat (2) @(negedge clk);
        cfg_psize = cfg;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_psize = ~cfg;
        @(negedge clk);
    endtask

    function automatic int expect_hit(input int a, input int base, input int mask,
                                      input int vld, input int wp, input int w);
        if (vld == 0) return 0;
        if (wp != 0 && w != 0) return 0;
        return (((a ^ base) & mask) == 0) ? 1 : 0;
    endfunction

    initial begin
        rst_n = 1'b0; cfg_psize = '0; wr_base = 0; wr_opt = 0; wdata = '0;
        acc_valid = 0; acc_write = 0; acc_addr = '0;

        // R1 and R9: reset state, port size from last reset edge
        do_reset(2'b01);
        check("R1 boot after reset", int'(boot), 1);
        check("R1 cs low after reset", int'(cs0), 0);
        check("R1 port size latched", int'(psize), 1);
        check("R9 port size ignores pins", int'(psize), 1);

        // R3: idle cycles leave select low
        @(negedge clk);
        check("R3 idle low", int'(cs0), 0);

        // R2: boot mode selects every address, read and write
        for (int a = 0; a < NADDR; a++) begin
            for (int w = 0; w < 2; w++) begin
                access(a[AW-1:0], w[0]);
                check("R2 boot select", int'(cs0), 1);
                @(negedge clk);
                check("R3 one cycle only", int'(cs0), 0);
            end
        end

        // R4: base write alone keeps boot, write-protect ignored in boot
        reg_write(1'b0, {1'b1, 1'b1, 6'b101000});
        check("R4 base write keeps boot", int'(boot), 1);
        access(6'd3, 1'b1);
        check("R2 boot ignores write-protect", int'(cs0), 1);

        // R5: option write and access on the same edge
        @(negedge clk);
        wdata = {2'b00, 6'b111000}; wr_opt = 1'b1;
        acc_valid = 1'b1; acc_addr = 6'd0; acc_write = 1'b0;
        @(negedge clk);
        wr_opt = 1'b0; acc_valid = 1'b0;
        check("R5 same-edge access decoded in boot", int'(cs0), 1);
        check("R5 boot ended", int'(boot), 0);

        // R6 and R7: decode sweep with valid=1, write-protect=1
        for (int a = 0; a < NADDR; a++) begin
            for (int w = 0; w < 2; w++) begin
                access(a[AW-1:0], w[0]);
                if (w == 0)
                    check("R6 decode", int'(cs0), expect_hit(a, 40, 56, 1, 1, w));
                else
                    check("R7 write-protect", int'(cs0), expect_hit(a, 40, 56, 1, 1, w));
            end
        end

        // R7: write-protect cleared, writes decode
        reg_write(1'b0, {1'b1, 1'b0, 6'b010100});
        for (int a = 0; a < NADDR; a++) begin
            access(a[AW-1:0], 1'b1);
            check("R7 writes allowed", int'(cs0), expect_hit(a, 20, 56, 1, 0, 1));
        end

        // R6: valid bit clear blocks all
        reg_write(1'b0, {1'b0, 1'b0, 6'b010100});
        for (int a = 0; a < NADDR; a += 5) begin
            access(a[AW-1:0], 1'b0);
            check("R6 valid clear", int'(cs0), 0);
        end

        // R8: no write re-enables boot
        reg_write(1'b1, '1);
        check("R8 opt write no reentry", int'(boot), 0);
        reg_write(1'b0, {1'b1, 1'b0, 6'b000000});
        check("R8 base write no reentry", int'(boot), 0);
        access(6'd1, 1'b0);
        check("R8 decode still normal", int'(cs0), 0);
        access(6'd0, 1'b0);
        check("R6 full-mask match", int'(cs0), 1);

        // R10: reset again restores boot and resamples size
        do_reset(2'b11);
        check("R10 boot restored", int'(boot), 1);
        check("R10 port size resampled", int'(psize), 3);
        access(6'd17, 1'b1);
        check("R10 boot select", int'(cs0), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule